// File: doc/BRIEF.md
# Multi-lane ADC sample transport packer

This block sits between a 12-bit ADC sample stream and the transport layer of a multi-lane serial link. It gathers one frame's worth of samples and then emits the frame as one octet per lane per clock, on up to sixteen lanes at once. The lanes form two groups of eight. Group A drives output lanes 0 to 7 and group B drives lanes 8 to 15. Each group receives its own stream of samples.

The input runs in one of two ways. In single-channel operation, each accepted beat carries one sample. Beats alternate between the two groups, so even-numbered samples go to group A and odd-numbered samples go to group B. In dual-channel operation, each beat carries one sample of channel A and one of channel B, and each channel feeds its own group.

Four lane formats are available:
- two tail-padded formats, with five samples plus four zero bits per lane;
- a dense format that slices four samples across three lanes at nibble boundaries;
- an octet format that sends the top eight bits of one sample per lane.

The format and the channel arrangement are captured once per frame, with the frame's first beat.

Top module: `lane_packer`

## Requirements
- R1: During and right after reset, `out_valid` and `out_sof` are 0, `out_data` is all zero and `in_ready` is 1.
- R2: `mode_i[2:1]` selects the format and `mode_i[0]` selects dual-channel (1) or single-channel (0). The encodings are: 0 = padded with 4 lanes per group, 1 = padded with 8 lanes per group, 2 = dense with 6 lanes per group, 3 = octet with 4 lanes per group. The mode is captured with the first accepted beat of a frame. Changes to `mode_i` at any later point of that frame have no effect on the frame.
- R3: In single-channel mode, accepted beat b carries sample `in_samp_a`. Even b goes to group A at stream index b/2 and odd b goes to group B at index (b-1)/2. `in_samp_b` is ignored.
- R4: In dual-channel mode, accepted beat b places `in_samp_a` at group A stream index b and `in_samp_b` at group B stream index b.
- R5: In the padded formats with L lanes per group, lane k of a group sends the stream entries k, k+L, k+2L, k+3L and k+4L in that order. Each sample is sent MSB first and is followed by 4 zero tail bits, which gives 8 octets per frame.
- R6: In the dense format, lane k of a group (k < 6) belongs to triad t = k/3 at position r = k%3. The triad's 48-bit string is entries 4t, 4t+1, 4t+2 and 4t+3 concatenated MSB first. Lane r sends bits [47-16r : 32-16r] of that string as 2 octets.
- R7: In the octet format, lane k of a group (k < 4) sends bits [11:4] of stream entry k as its single octet.
- R8: Lane j occupies `out_data[8j+7:8j]`. Lanes 0-7 are group lanes 0-7 of group A, and lanes 8-15 are group lanes 0-7 of group B. Lanes beyond the format's per-group lane count are zero.
- R9: A frame's octets appear on consecutive cycles, with `out_sof` high on the first octet only. `in_ready` is low from the cycle after the frame's final beat until the cycle that presents the final octet, and it is high in that cycle.
- R10: A frame completes after exactly S beats in dual-channel mode and 2S beats in single-channel mode. S is 20, 40, 8 or 4 for formats 0 to 3. Each frame emits exactly 8, 8, 2 or 1 octet cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Format in bits 2:1, dual-channel select in bit 0 |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Packer accepts a beat this cycle |
| in_samp_a | input | 12 | Sample for single-channel or channel A, offset binary |
| in_samp_b | input | 12 | Channel B sample (dual-channel only) |
| out_valid | output | 1 | Octets on `out_data` are valid |
| out_sof | output | 1 | First octet cycle of a frame |
| out_data | output | 128 | Sixteen lane octets, lane j in bits 8j+7:8j |

## Verification
The bound checker covers the properties that hold on every cycle:
- the framing of the octet burst: a start flag only with valid data, consecutive octets, and a burst length that matches the captured format;
- `in_ready` low while a frame drains;
- the zero tail nibble on the last padded octet;
- silent unused lanes;
- the captured mode held stable inside a frame.

The placement of individual samples can only be shown by the scoreboard scenarios. These cover:
- the even/odd split in single-channel mode;
- the per-channel groups in dual-channel mode;
- the lane strides of both padded widths;
- nibble slicing across lane boundaries in dense mode;
- truncation to the upper octet.

The scenarios also show that a mid-frame mode change is ignored, with all-ones data, gaps in `in_valid` and back-to-back frames.

// File: rtl/lane_packer_pkg.sv
`timescale 1ns/1ps
package lane_packer_pkg;

    typedef enum logic [1:0] {
        FMT_PAD_HALF = 2'd0,
        FMT_PAD_FULL = 2'd1,
        FMT_DENSE    = 2'd2,
        FMT_BYTE     = 2'd3
    } fmt_e;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_EMIT   = 1'b1
    } phase_e;

    function automatic fmt_e fmt_of(input logic [2:0] m);
        return fmt_e'(m[2:1]);
    endfunction

endpackage

// File: rtl/lane_packer_gather.sv
`timescale 1ns/1ps
module lane_packer_gather #(
    parameter int SAMP_W = 12,
    parameter int SLOTS  = 40,
    parameter int CNT_W  = 7
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic                                   dual,
    input  logic [CNT_W-1:0]                       beat_idx,
    input  logic [SAMP_W-1:0]                      samp_a,
    input  logic [SAMP_W-1:0]                      samp_b,
    output logic [1:0][SLOTS-1:0][SAMP_W-1:0]      bank_o
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [1:0][SLOTS-1:0][SAMP_W-1:0] bank_d, bank_q;
    logic [SLOT_W-1:0]                 slot;

    always_comb begin
        bank_d = bank_q;
        slot   = dual ? SLOT_W'(beat_idx) : SLOT_W'(beat_idx >> 1);
        if (wr_en) begin
            if (dual) begin
                bank_d[0][slot] = samp_a;
                bank_d[1][slot] = samp_b;
            end else begin
                bank_d[beat_idx[0]][slot] = samp_a;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank_o = bank_q;

endmodule

// File: rtl/lane_packer_framer.sv
`timescale 1ns/1ps
module lane_packer_framer import lane_packer_pkg::*; #(
    parameter int SAMP_W      = 12,
    parameter int OCT_W       = 8,
    parameter int GRP_LANES   = 8,
    parameter int PAD_SAMPLES = 5,
    parameter int SLOTS       = 40,
    parameter int OCTS_PAD    = 8,
    parameter int OCT_IDX_W   = 3
) (
    input  logic [1:0][SLOTS-1:0][SAMP_W-1:0]       bank,
    input  fmt_e                                    fmt,
    input  logic [OCT_IDX_W-1:0]                    oct_idx,
    output logic [2*GRP_LANES-1:0][OCT_W-1:0]       lanes_o
);
    localparam int WORD_W      = OCTS_PAD * OCT_W;
    localparam int HALF        = GRP_LANES / 2;
    localparam int TRI         = GRP_LANES / 3;
    localparam int DENSE_LANES = 3 * TRI;
    localparam int DENSE_BITS  = (4 * SAMP_W) / 3;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        for (genvar k = 0; k < GRP_LANES; k++) begin : g_lane
            localparam int T = k / 3;
            localparam int R = k % 3;

            logic [WORD_W-1:0]   word;
            logic [4*SAMP_W-1:0] triad;

            always_comb begin
                word  = '0;
                triad = '0;
                unique case (fmt)
                    FMT_PAD_HALF: begin
                        if (k < HALF) begin
                            for (int m = 0; m < PAD_SAMPLES; m++)
                                word[WORD_W-1-m*SAMP_W -: SAMP_W] = bank[g][k+m*HALF];
                        end
                    end
                    FMT_PAD_FULL: begin
                        for (int m = 0; m < PAD_SAMPLES; m++)
                            word[WORD_W-1-m*SAMP_W -: SAMP_W] = bank[g][k+m*GRP_LANES];
                    end
                    FMT_DENSE: begin
                        if (k < DENSE_LANES) begin
                            triad = {bank[g][4*T], bank[g][4*T+1],
                                     bank[g][4*T+2], bank[g][4*T+3]};
                            word[WORD_W-1 -: DENSE_BITS] =
                                triad[DENSE_BITS*(3-R)-1 -: DENSE_BITS];
                        end
                    end
                    FMT_BYTE: begin
                        if (k < HALF)
                            word[WORD_W-1 -: OCT_W] = bank[g][k][SAMP_W-1 -: OCT_W];
                    end
                endcase
            end

            assign lanes_o[g*GRP_LANES+k] =
                word[(OCTS_PAD - 1 - int'(oct_idx)) * OCT_W +: OCT_W];
        end
    end

endmodule

// File: rtl/lane_packer.sv
`timescale 1ns/1ps
module lane_packer import lane_packer_pkg::*; #(
    parameter int SAMP_W      = 12,
    parameter int OCT_W       = 8,
    parameter int GRP_LANES   = 8,
    parameter int PAD_SAMPLES = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0]                    mode_i,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [SAMP_W-1:0]             in_samp_a,
    input  logic [SAMP_W-1:0]             in_samp_b,
    output logic                          out_valid,
    output logic                          out_sof,
    output logic [2*GRP_LANES*OCT_W-1:0]  out_data
);
    localparam int LANES       = 2 * GRP_LANES;
    localparam int SLOTS_FULL  = PAD_SAMPLES * GRP_LANES;
    localparam int SLOTS_HALF  = SLOTS_FULL / 2;
    localparam int SLOTS_DENSE = 4 * (GRP_LANES / 3);
    localparam int SLOTS_BYTE  = GRP_LANES / 2;
    localparam int CNT_W       = $clog2(2 * SLOTS_FULL + 1);
    localparam int OCTS_PAD    = (PAD_SAMPLES * SAMP_W + OCT_W - 1) / OCT_W;
    localparam int OCTS_DENSE  = ((4 * SAMP_W) / 3) / OCT_W;
    localparam int OCT_IDX_W   = (OCTS_PAD > 1) ? $clog2(OCTS_PAD) : 1;

    typedef struct packed {
        phase_e                       phase;
        logic [CNT_W-1:0]             beats;
        logic [OCT_IDX_W-1:0]         oct;
        logic [2:0]                   mode;
        logic                         vld;
        logic                         sof;
        logic [LANES-1:0][OCT_W-1:0]  data;
    } st_t;

    function automatic logic [CNT_W-1:0] beats_for(input logic [2:0] m);
        int s;
        s = 0;
        case (fmt_of(m))
            FMT_PAD_HALF: s = SLOTS_HALF;
            FMT_PAD_FULL: s = SLOTS_FULL;
            FMT_DENSE:    s = SLOTS_DENSE;
            FMT_BYTE:     s = SLOTS_BYTE;
        endcase
        return CNT_W'(m[0] ? s : 2 * s);
    endfunction

    function automatic logic [OCT_IDX_W-1:0] last_oct(input fmt_e f);
        case (f)
            FMT_DENSE: return OCT_IDX_W'(OCTS_DENSE - 1);
            FMT_BYTE:  return '0;
            default:   return OCT_IDX_W'(OCTS_PAD - 1);
        endcase
    endfunction

    st_t                                   st_d, st_q;
    logic [2:0]                            eff_mode;
    logic                                  fire;
    logic [1:0][SLOTS_FULL-1:0][SAMP_W-1:0] bank;
    logic [LANES-1:0][OCT_W-1:0]           lane_oct;
    logic [2:0]                            frame_mode;
    logic [CNT_W-1:0]                      beat_cnt;

    lane_packer_gather #(
        .SAMP_W (SAMP_W),
        .SLOTS  (SLOTS_FULL),
        .CNT_W  (CNT_W)
    ) gather_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fire),
        .dual     (eff_mode[0]),
        .beat_idx (st_q.beats),
        .samp_a   (in_samp_a),
        .samp_b   (in_samp_b),
        .bank_o   (bank)
    );

    lane_packer_framer #(
        .SAMP_W      (SAMP_W),
        .OCT_W       (OCT_W),
        .GRP_LANES   (GRP_LANES),
        .PAD_SAMPLES (PAD_SAMPLES),
        .SLOTS       (SLOTS_FULL),
        .OCTS_PAD    (OCTS_PAD),
        .OCT_IDX_W   (OCT_IDX_W)
    ) framer_i (
        .bank    (bank),
        .fmt     (fmt_of(st_q.mode)),
        .oct_idx (st_q.oct),
        .lanes_o (lane_oct)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.sof  = 1'b0;
        st_d.data = '0;
        eff_mode  = (st_q.beats == '0) ? mode_i : st_q.mode;
        in_ready  = (st_q.phase == PH_GATHER);
        fire      = in_valid & in_ready;

        unique case (st_q.phase)
            PH_GATHER: begin
                if (fire) begin
                    st_d.mode = eff_mode;
                    if (st_q.beats == beats_for(eff_mode) - 1'b1) begin
                        st_d.phase = PH_EMIT;
                        st_d.beats = '0;
                        st_d.oct   = '0;
                    end else begin
                        st_d.beats = st_q.beats + 1'b1;
                    end
                end
            end
            PH_EMIT: begin
                st_d.vld  = 1'b1;
                st_d.sof  = (st_q.oct == '0);
                st_d.data = lane_oct;
                if (st_q.oct == last_oct(fmt_of(st_q.mode)))
                    st_d.phase = PH_GATHER;
                else
                    st_d.oct = st_q.oct + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_GATHER, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_sof    = st_q.sof;
    assign out_data   = st_q.data;
    assign frame_mode = st_q.mode;
    assign beat_cnt   = st_q.beats;

endmodule

// File: rtl/lane_packer_chk.sv
`timescale 1ns/1ps
module lane_packer_chk #(
    parameter int SAMP_W      = 12,
    parameter int OCT_W       = 8,
    parameter int GRP_LANES   = 8,
    parameter int PAD_SAMPLES = 5,
    parameter int CNT_W       = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_ready,
    input logic                          out_valid,
    input logic                          out_sof,
    input logic [2*GRP_LANES*OCT_W-1:0]  out_data,
    input logic [2:0]                    frame_mode,
    input logic [CNT_W-1:0]              beat_cnt
);
    localparam int LANES      = 2 * GRP_LANES;
    localparam int OCTS_PAD   = (PAD_SAMPLES * SAMP_W + OCT_W - 1) / OCT_W;
    localparam int OCTS_DENSE = ((4 * SAMP_W) / 3) / OCT_W;
    localparam int TAIL_W     = OCTS_PAD * OCT_W - PAD_SAMPLES * SAMP_W;

    function automatic int octs_for(input logic [1:0] f);
        case (f)
            2'd2:    return OCTS_DENSE;
            2'd3:    return 1;
            default: return OCTS_PAD;
        endcase
    endfunction

    function automatic int used_for(input logic [1:0] f);
        case (f)
            2'd1:    return GRP_LANES;
            2'd2:    return 3 * (GRP_LANES / 3);
            default: return GRP_LANES / 2;
        endcase
    endfunction

    logic [2:0] lat_mode_q;
    logic [7:0] prev_idx_q;
    logic [7:0] cur_idx;
    int         octs;
    logic       tail_nz;
    logic       unused_nz;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_mode_q <= '0;
            prev_idx_q <= '0;
        end else begin
            lat_mode_q <= frame_mode;
            if (out_valid) prev_idx_q <= cur_idx;
        end
    end

    always_comb begin
        cur_idx   = out_sof ? 8'd0 : prev_idx_q + 8'd1;
        octs      = octs_for(lat_mode_q[2:1]);
        tail_nz   = 1'b0;
        unused_nz = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            tail_nz = tail_nz | (|out_data[j*OCT_W +: TAIL_W]);
            if ((j % GRP_LANES) >= used_for(lat_mode_q[2:1]))
                unused_nz = unused_nz | (|out_data[j*OCT_W +: OCT_W]);
        end
    end

    // R9: the frame-start flag only accompanies valid octets
    a_r9_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R9: octets after the first follow a valid cycle directly
    a_r9_octets_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> $past(out_valid));

    // R9: input is held off while the frame still drains
    a_r9_ready_low_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(cur_idx) < octs - 1) |-> !in_ready);

    // R10: a burst continues until its format's octet count
    a_r10_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(cur_idx) < octs - 1) |=> (out_valid && !out_sof));

    // R10: a burst stops after its format's octet count
    a_r10_burst_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(cur_idx) == octs - 1) |=> (!out_valid || out_sof));

    // R5: tail bits of the last padded octet are zero on every lane
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lat_mode_q[2] == 1'b0 && int'(cur_idx) == OCTS_PAD - 1) |-> !tail_nz);

    // R8: lanes beyond the format's lane count stay silent
    a_r8_unused_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !unused_nz);

    // R2: the captured mode cannot change inside a frame
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_cnt != '0 || !in_ready) |=> $stable(frame_mode));

endmodule

bind lane_packer lane_packer_chk #(
    .SAMP_W      (SAMP_W),
    .OCT_W       (OCT_W),
    .GRP_LANES   (GRP_LANES),
    .PAD_SAMPLES (PAD_SAMPLES),
    .CNT_W       (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_data   (out_data),
    .frame_mode (frame_mode),
    .beat_cnt   (beat_cnt)
);

// File: tb/lane_packer_tb_top.sv
`timescale 1ns/1ps
module lane_packer_tb_top;
    localparam int SW = 12;
    localparam int LN = 16;
    localparam int NS = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_i = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_samp_a = '0;
    logic [SW-1:0] in_samp_b = '0;
    logic          out_valid;
    logic          out_sof;
    logic [127:0]  out_data;

    always #2.5 clk = ~clk;

    lane_packer dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_samp_a(in_samp_a), .in_samp_b(in_samp_b),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    typedef struct {
        logic [127:0] data;
        logic         sof;
        logic         last;
        string        tag;
    } exp_t;

    exp_t          sb[$];
    exp_t          e;
    int            n_chk = 0;
    int            n_fail = 0;
    logic [SW-1:0] ga[NS];
    logic [SW-1:0] gb[NS];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pat(int seed, int g, int i);
        if (seed == 0) return 12'hFFF;
        return 12'((seed * 1237 + i * 389 + g * 2731 + i * i * 7) % 4096);
    endfunction

    function automatic logic [SW-1:0] ent(int g, int i);
        return (g == 0) ? ga[i] : gb[i];
    endfunction

    // expected lane bit string, MSB first, from R5, R6 and R7
    function automatic logic [63:0] lane_word(int fmt, int g, int k);
        logic [63:0] w;
        logic [47:0] t3;
        w = '0;
        case (fmt)
            0: if (k < 4) for (int m = 0; m < 5; m++) w[63-12*m -: 12] = ent(g, k + 4*m);
            1: for (int m = 0; m < 5; m++) w[63-12*m -: 12] = ent(g, k + 8*m);
            2: if (k < 6) begin
                   t3 = {ent(g, 4*(k/3)), ent(g, 4*(k/3)+1), ent(g, 4*(k/3)+2), ent(g, 4*(k/3)+3)};
                   w[63 -: 16] = t3[47-16*(k%3) -: 16];
               end
            default: if (k < 4) w[63 -: 8] = ent(g, k)[11:4];
        endcase
        return w;
    endfunction

    task automatic push_expect(int fmt, string tag);
        int octs;
        exp_t x;
        octs = (fmt < 2) ? 8 : ((fmt == 2) ? 2 : 1);
        for (int o = 0; o < octs; o++) begin
            x.data = '0;
            for (int j = 0; j < LN; j++) begin
                logic [63:0] w;
                w = lane_word(fmt, j / 8, j % 8);
                x.data[8*j +: 8] = w[63-8*o -: 8];
            end
            x.sof  = (o == 0);
            x.last = (o == octs - 1);
            x.tag  = tag;
            sb.push_back(x);
        end
    endtask

    task automatic beat(input logic [SW-1:0] a, input logic [SW-1:0] b, input int gap);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
        in_samp_a = a;
        in_samp_b = b;
        in_valid  = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_frame(int m, int seed, int alt, int gap);
        int fmt, slots, nb;
        bit dual;
        string tag;
        fmt  = m >> 1;
        dual = m[0];
        case (fmt)
            0: begin slots = 20; tag = "R5"; end
            1: begin slots = 40; tag = "R5"; end
            2: begin slots = 8;  tag = "R6"; end
            default: begin slots = 4; tag = "R7"; end
        endcase
        tag = {tag, dual ? " R4" : " R3", (alt >= 0) ? " R2" : ""};
        for (int i = 0; i < NS; i++) begin
            ga[i] = pat(seed, 0, i);
            gb[i] = pat(seed, 1, i);
        end
        mode_i = 3'(m);
        nb = dual ? slots : 2 * slots;
        for (int b = 0; b < nb; b++) begin
            if (dual) beat(ga[b], gb[b], gap);
            else      beat((b % 2 == 1) ? gb[b/2] : ga[b/2], pat(seed + 77, 1, b), gap);
            if (b == 0 && alt >= 0) mode_i = 3'(alt);
            if (b == nb - 1) push_expect(fmt, tag);
        end
        // R10: the frame closes exactly at its final beat
        check(in_ready == 1'b0, "R10", "ready after final beat", 128'(in_ready), 128'(0));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "octet beyond frame length", out_data, '0);
            end else begin
                e = sb.pop_front();
                check(out_data == e.data, {e.tag, " R8"}, "lane octets", out_data, e.data);
                check(out_sof == e.sof, "R9", "frame start flag", 128'(out_sof), 128'(e.sof));
                check(in_ready == e.last, "R9", "ready while draining", 128'(in_ready), 128'(e.last));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", 128'(out_valid), 128'(0));
        check(out_sof == 1'b0, "R1", "out_sof", 128'(out_sof), 128'(0));
        check(out_data == '0, "R1", "out_data", out_data, '0);
        check(in_ready == 1'b1, "R1", "in_ready", 128'(in_ready), 128'(1));

        for (int m = 0; m < 8; m++) run_frame(m, m + 1, -1, 0);
        run_frame(0, 0, -1, 0);
        run_frame(1, 0, -1, 0);
        run_frame(6, 0, -1, 0);
        run_frame(4, 9, 7, 0);
        run_frame(7, 11, 2, 0);
        run_frame(2, 12, 5, 0);
        run_frame(3, 13, -1, 2);
        run_frame(5, 14, -1, 1);

        repeat (20) @(negedge clk);
        check(sb.size() == 0, "R10", "frames fully drained", 128'(sb.size()), 128'(0));
        check(out_valid == 1'b0, "R9", "idle after drain", 128'(out_valid), 128'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule